// File: doc/BRIEF.md
# Interrupt Flag and Request Controller

This block gathers interrupt events for a small 8-bit processor core and reduces them to one request line. It watches an external interrupt pin on a programmable edge and a group of port pins for any change of level. It also takes two single-cycle pulses from the rest of the chip: a timer rollover and the end of a non-volatile memory write. Each source has a sticky flag. A flag is set by its event whatever the enable bits hold, and it stays set until software clears it.

The request output comes from two levels of gating. Each flag is first ANDed with its own enable bit. The memory-write source is then ANDed with a peripheral enable, which has no effect on the three core sources. A global enable masks the result. Software reaches the block through a small register port of four locations: a control byte, the flag byte, a view of the synchronised port pins and a reserved location. A read of the port location also refreshes the snapshot that the change detector compares against. The normal software routine is therefore to read the port and then clear the change flag.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the control byte (select 0) and the flag byte (select 1) read 0x00, and `irq_req` is 0.
- R2: With the edge-select bit (control bit 6) at 1, a rising level on `int_pin` sets the pin flag (flag bit 1) and a falling level leaves it clear.
- R3: With control bit 6 at 0, a falling level on `int_pin` sets flag bit 1 and a rising level leaves it clear.
- R4: The change flag (flag bit 2) sets whenever a monitored pin (`port_in[7:4]`) differs from the snapshot, whether it rose or fell. The snapshot is loaded from the synchronised pins on each read of select 2, and that read returns the synchronised `port_in`.
- R5: A monitored pin whose `chg_dir` bit is 0 (configured as an output) never sets flag bit 2.
- R6: A `tmr_ovf` pulse sets the timer flag (flag bit 0), and an `nvm_done` pulse sets the memory flag (flag bit 3).
- R7: A write to select 1 clears each flag whose data bit is 0 and leaves a flag unchanged where the data bit is 1. Flags otherwise hold their value.
- R8: If a set event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: Flags set even when their enables are 0, and the request stays low while no set flag is enabled.
- R10: With the global enable (control bit 0) at 0, `irq_req` is 0 whatever the flags and the other enables hold.
- R11: The peripheral enable (control bit 1) gates only the memory flag. The timer, pin and change flags raise `irq_req` through their enables (control bits 2, 3 and 4) regardless of it, while the memory flag also needs its own enable (control bit 5).
- R12: Level changes on `port_in[3:0]` never set flag bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_pin | input | 1 | External interrupt pin, asynchronous |
| port_in | input | PORT_W (8) | Port pin levels, asynchronous |
| chg_dir | input | CHG_W (4) | Direction of the monitored pins, 1 = input |
| tmr_ovf | input | 1 | Single-cycle timer rollover pulse |
| nvm_done | input | 1 | Single-cycle memory-write-complete pulse |
| reg_sel | input | 2 | Register select: 0 control, 1 flags, 2 port, 3 reserved |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid in the cycle of the strobe |
| irq_req | output | 1 | Interrupt request to the core |

## Verification
The assertions assume that `tmr_ovf` and `nvm_done` are synchronous to `clk` and that `reg_wr` and `reg_rd` are never raised together. They also assume that the pins are low while reset is applied, so the first synchronised sample cannot look like an edge. The stimulus changes inputs only on falling clock edges, pulses each event line for exactly one cycle, and holds every pin level for at least four cycles so that it crosses the synchroniser before it is checked. The stimulus also always reads the port before it clears the change flag, so a stale snapshot cannot set the flag again.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
   localparam int REG_W = 8;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_FLAG = 2'd1,
      SEL_PORT = 2'd2,
      SEL_RSVD = 2'd3
   } reg_sel_e;

   // control byte bit positions
   localparam int CB_GLB  = 0;
   localparam int CB_PERI = 1;
   localparam int CB_TMR  = 2;
   localparam int CB_PIN  = 3;
   localparam int CB_CHG  = 4;
   localparam int CB_NVM  = 5;
   localparam int CB_RISE = 6;

   // flag byte bit positions
   localparam int FB_TMR  = 0;
   localparam int FB_PIN  = 1;
   localparam int FB_CHG  = 2;
   localparam int FB_NVM  = 3;
   localparam int NUM_SRC = 4;
endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      if (STAGES < 2) $error("irqf_sync: STAGES must be at least 2");
      if (W < 1)      $error("irqf_sync: W must be positive");
   end

   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irqf_edge.sv
module irqf_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic rise_sel,
   output logic evt
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign evt = rise_sel ? (lvl & ~prev_q) : (~lvl & prev_q);
endmodule

// File: rtl/irqf_chg.sv
module irqf_chg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] live,
   input  logic [W-1:0] dir_in,
   input  logic         load,
   output logic         evt
);
   initial begin
      if (W < 1) $error("irqf_chg: W must be positive");
   end

   logic [W-1:0] snap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    snap_q <= '0;
      else if (load) snap_q <= live;
   end

   assign evt = |((live ^ snap_q) & dir_in);

   // R4: after a load, the snapshot holds the levels seen at the load
   a_r4_snap_loaded: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (snap_q == $past(live)));
endmodule

// File: rtl/irqf_flags.sv
module irqf_flags #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] flag_q
);
   initial begin
      if (N < 1) $error("irqf_flags: N must be positive");
   end

   generate
      for (genvar b = 0; b < N; b++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q[b] <= 1'b0;
            else if (set_i[b]) flag_q[b] <= 1'b1;
            else if (clr_i[b]) flag_q[b] <= 1'b0;
         end

         // R8: a set event always leaves the flag set
         a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[b] |=> flag_q[b]);

         // R7: a set flag holds until it is cleared
         a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[b] && !clr_i[b]) |=> flag_q[b]);
      end
   endgenerate
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
   import irqf_pkg::*;
#(
   parameter int PORT_W      = 8,
   parameter int CHG_LO      = 4,
   parameter int CHG_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              int_pin,
   input  logic [PORT_W-1:0] port_in,
   input  logic [CHG_W-1:0]  chg_dir,
   input  logic              tmr_ovf,
   input  logic              nvm_done,
   input  logic [1:0]        reg_sel,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq_req
);
   localparam int SYNC_W = PORT_W + 1;
   localparam int CHG_HI = CHG_LO + CHG_W - 1;

   initial begin
      if (PORT_W > REG_W)   $error("irq_flag_ctrl: PORT_W exceeds register width");
      if (CHG_HI >= PORT_W) $error("irq_flag_ctrl: monitored pins outside port");
      if (CHG_W < 1)        $error("irq_flag_ctrl: CHG_W must be positive");
   end

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_sel);

   // synchronised pins: bit PORT_W is the interrupt pin
   logic [SYNC_W-1:0] sync_q;
   logic [PORT_W-1:0] port_s;
   logic              pin_s;

   irqf_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({int_pin, port_in}),
      .q     (sync_q)
   );

   assign port_s = sync_q[PORT_W-1:0];
   assign pin_s  = sync_q[PORT_W];

   // control register
   logic [REG_W-1:0] ctrl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ctrl_q <= '0;
      else if (reg_wr && sel == SEL_CTRL)  ctrl_q <= reg_wdata;
   end

   // source detectors
   logic pin_evt;
   logic chg_evt;
   logic port_load;

   irqf_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (pin_s),
      .rise_sel (ctrl_q[CB_RISE]),
      .evt      (pin_evt)
   );

   assign port_load = reg_rd && (sel == SEL_PORT);

   irqf_chg #(.W(CHG_W)) u_chg (
      .clk    (clk),
      .rst_n  (rst_n),
      .live   (port_s[CHG_HI:CHG_LO]),
      .dir_in (chg_dir),
      .load   (port_load),
      .evt    (chg_evt)
   );

   // flag bank
   logic [NUM_SRC-1:0] set_v;
   logic [NUM_SRC-1:0] clr_v;
   logic [NUM_SRC-1:0] flags;

   always_comb begin
      set_v         = '0;
      set_v[FB_TMR] = tmr_ovf;
      set_v[FB_PIN] = pin_evt;
      set_v[FB_CHG] = chg_evt;
      set_v[FB_NVM] = nvm_done;
      clr_v = (reg_wr && sel == SEL_FLAG) ? ~reg_wdata[NUM_SRC-1:0] : '0;
   end

   irqf_flags #(.N(NUM_SRC)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v),
      .clr_i  (clr_v),
      .flag_q (flags)
   );

   // request gating: core sources, then the peripheral source, then global
   logic core_hit;
   logic peri_hit;

   assign core_hit = (flags[FB_TMR] & ctrl_q[CB_TMR])
                   | (flags[FB_PIN] & ctrl_q[CB_PIN])
                   | (flags[FB_CHG] & ctrl_q[CB_CHG]);
   assign peri_hit = flags[FB_NVM] & ctrl_q[CB_NVM] & ctrl_q[CB_PERI];
   assign irq_req  = ctrl_q[CB_GLB] & (core_hit | peri_hit);

   // read mux
   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         SEL_CTRL: reg_rdata = ctrl_q;
         SEL_FLAG: reg_rdata[NUM_SRC-1:0] = flags;
         SEL_PORT: reg_rdata[PORT_W-1:0] = port_s;
         SEL_RSVD: reg_rdata = '0;
      endcase
   end

   // R2: a detected pin edge shows up in the pin flag
   a_r2_pin_flag: assert property (@(posedge clk) disable iff (!rst_n)
      pin_evt |=> flags[FB_PIN]);

   // R4: a detected port change shows up in the change flag
   a_r4_chg_flag: assert property (@(posedge clk) disable iff (!rst_n)
      chg_evt |=> flags[FB_CHG]);

   // R10: a cleared global enable keeps the request low
   a_r10_glb_mask: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CB_GLB] |-> !irq_req);

   // R9: the request only rises while some flag is set
   a_r9_req_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (flags != '0));
endmodule

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
   localparam time TCK = 8ns;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       int_pin = 1'b0;
   logic [7:0] port_in = 8'h00;
   logic [3:0] chg_dir = 4'hF;
   logic       tmr_ovf = 1'b0;
   logic       nvm_done = 1'b0;
   logic [1:0] reg_sel = 2'd0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq_req;

   int checks = 0;
   int errors = 0;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #(TCK/2) clk = ~clk;

   irq_flag_ctrl dut (
      .clk(clk), .rst_n(rst_n), .int_pin(int_pin), .port_in(port_in),
      .chg_dir(chg_dir), .tmr_ovf(tmr_ovf), .nvm_done(nvm_done),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req)
   );

   // monitor: compares read data against the scoreboard queue
   always begin
      @(negedge clk);
      #2;
      if (reg_rd && exp_q.size() > 0) begin
         logic [7:0] e;
         string      t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         checks++;
         if (reg_rdata !== e) begin
            errors++;
            $display("FAIL %s: read sel %0d got %02h expected %02h", t, reg_sel, reg_rdata, e);
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] s, input logic [7:0] e, input string t);
      @(negedge clk);
      reg_sel = s; reg_rd = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic chk_irq(input logic e, input string t);
      #2;
      checks++;
      if (irq_req !== e) begin
         errors++;
         $display("FAIL %s: irq_req got %0b expected %0b", t, irq_req, e);
      end
   endtask

   task automatic pulse_tmr();
      @(negedge clk); tmr_ovf = 1'b1;
      @(negedge clk); tmr_ovf = 1'b0;
   endtask

   task automatic pulse_nvm();
      @(negedge clk); nvm_done = 1'b1;
      @(negedge clk); nvm_done = 1'b0;
   endtask

   initial begin
      #(TCK * 200000);
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      chk_irq(1'b0, "R1");
      rd(2'd0, 8'h00, "R1");
      rd(2'd1, 8'h00, "R1");

      // R2 rising edge select
      wr(2'd0, 8'h40);
      @(negedge clk); int_pin = 1'b1; idle(4);
      rd(2'd1, 8'h02, "R2");
      wr(2'd1, 8'hFD);                     // R7 clear only the pin flag
      rd(2'd1, 8'h00, "R7");
      @(negedge clk); int_pin = 1'b0; idle(4);
      rd(2'd1, 8'h00, "R2");

      // R3 falling edge select
      wr(2'd0, 8'h00);
      @(negedge clk); int_pin = 1'b1; idle(4);
      rd(2'd1, 8'h00, "R3");
      @(negedge clk); int_pin = 1'b0; idle(4);
      rd(2'd1, 8'h02, "R3");
      wr(2'd1, 8'h00);
      rd(2'd1, 8'h00, "R3");

      // R4 port change both directions
      rd(2'd2, 8'h00, "R4");
      @(negedge clk); port_in = 8'h10; idle(4);
      rd(2'd1, 8'h04, "R4");
      rd(2'd2, 8'h10, "R4");
      wr(2'd1, 8'h00);
      rd(2'd1, 8'h00, "R4");
      @(negedge clk); port_in = 8'h00; idle(4);
      rd(2'd1, 8'h04, "R4");
      rd(2'd2, 8'h00, "R4");
      wr(2'd1, 8'h00);
      rd(2'd1, 8'h00, "R4");

      // R12 lower pins ignored
      @(negedge clk); port_in = 8'h0F; idle(4);
      rd(2'd1, 8'h00, "R12");
      rd(2'd2, 8'h0F, "R12");
      @(negedge clk); port_in = 8'h00; idle(4);

      // R5 output-configured pins ignored
      @(negedge clk); chg_dir = 4'b1110; port_in = 8'h10; idle(4);
      rd(2'd1, 8'h00, "R5");
      @(negedge clk); port_in = 8'h30; idle(4);
      rd(2'd1, 8'h04, "R5");
      @(negedge clk); port_in = 8'h00; chg_dir = 4'hF; idle(4);
      rd(2'd2, 8'h00, "R5");
      wr(2'd1, 8'h00);
      rd(2'd1, 8'h00, "R5");

      // R6 / R9 pulses set flags with enables off
      pulse_tmr(); idle(1);
      rd(2'd1, 8'h01, "R6");
      chk_irq(1'b0, "R9");
      pulse_nvm(); idle(1);
      rd(2'd1, 8'h09, "R6");
      chk_irq(1'b0, "R9");

      // R10 global enable
      wr(2'd0, 8'h26);
      chk_irq(1'b0, "R10");
      wr(2'd0, 8'h27);
      chk_irq(1'b1, "R10");

      // R11 peripheral enable gates only the memory flag
      wr(2'd1, 8'hFE);
      rd(2'd1, 8'h08, "R11");
      wr(2'd0, 8'h25);
      chk_irq(1'b0, "R11");
      wr(2'd0, 8'h27);
      chk_irq(1'b1, "R11");
      wr(2'd0, 8'h05);
      chk_irq(1'b0, "R11");
      pulse_tmr();
      chk_irq(1'b1, "R11");
      wr(2'd1, 8'h00);
      chk_irq(1'b0, "R7");

      // R8 set wins over clear in the same cycle
      @(negedge clk);
      reg_sel = 2'd1; reg_wdata = 8'h00; reg_wr = 1'b1; tmr_ovf = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; tmr_ovf = 1'b0;
      rd(2'd1, 8'h01, "R8");

      // R7 writing ones leaves flags alone
      wr(2'd1, 8'hFF);
      rd(2'd1, 8'h01, "R7");
      wr(2'd1, 8'h00);
      rd(2'd1, 8'h00, "R7");

      idle(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule